// File: doc/BRIEF.md
# Two-Port Hardware Semaphore Unit

This block gives two independent ports a set of eight binary tokens for mutual exclusion. Each port selects a token with the low three bits of its address, then writes to ask for or give back that token, or reads to learn whether it holds it. Software on either side claims a token by writing a zero in data bit 0 and frees it by writing a one. A read answers with the token state seen from that side, copied onto every data bit.

Each side keeps one request latch per token. A claim that loses stays pending in its latch. It takes the token on the same clock edge at which the holder gives it up. A read samples its answer on the first clock of the read strobe and keeps it steady for as long as the strobe stays asserted. Every input is sampled on the rising clock edge. When both sides claim a free token on the same edge, the left port wins.

Top module: `sem_token_unit`

## Requirements
- R1: After reset every request latch is clear and all eight tokens are free. A read of any token from either side returns all ones, and a data output whose side is not reading is all zeros.
- R2: A semaphore access uses only the low three address bits (a value from 0 to 7) to pick a token. All higher address bits are ignored.
- R3: A write is an edge on which the semaphore select and the write enable are both high. Data bit 0 low sets that side's request for the token, and data bit 0 high clears it. Data bits 15:1 are ignored.
- R4: A read returns one value on all 16 data bits. The value is all zeros when the reading side holds the token and all ones otherwise, so a free token reads all ones on both sides.
- R5: A request on a free token is granted on the same edge at which the request is written.
- R6: At most one side holds a given token. The holder keeps the token until it writes a one itself, whatever the other side writes.
- R7: When both sides write a request to the same free token on the same edge, the left side is granted.
- R8: A request from the side that does not hold the token stays pending. It takes the token on the edge at which the holder releases it.
- R9: A non-holder that writes a one withdraws its pending request. A later release by the holder then leaves the token free.
- R10: A read is active while the semaphore select and the output enable are both high. The value is captured on the first active edge and appears on the following cycle. It stays unchanged while the read stays active, even if the token state or the address changes. The output returns to zero one cycle after the read ends.
- R11: The eight tokens are independent. Accesses to one token leave the state of every other token unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset; frees all tokens |
| semSelL | input | 1 | Left semaphore select |
| wrEnL | input | 1 | Left write enable |
| rdEnL | input | 1 | Left output enable (read strobe) |
| addrL | input | ADDR_W | Left address; low three bits pick the token |
| wrDataL | input | DATA_W | Left write data; bit 0 is used |
| rdDataL | output | DATA_W | Left read data |
| semSelR | input | 1 | Right semaphore select |
| wrEnR | input | 1 | Right write enable |
| rdEnR | input | 1 | Right output enable (read strobe) |
| addrR | input | ADDR_W | Right address; low three bits pick the token |
| wrDataR | input | DATA_W | Right write data; bit 0 is used |
| rdDataR | output | DATA_W | Right read data |

## Verification
The bench uses the default parameters: a 14-bit address and a 16-bit data bus. The wide address lets it drive addresses whose upper bits differ but which alias onto the same token, which exercises the decode rule. The full data width lets it check that read data is replicated on every bit and that write bits above bit 0 have no effect. A behavioural model of the tokens and the latched reads is compared with both read outputs on every clock. The tests cover same-edge ties, pending claims that take over on release, withdrawn requests, and a release made while the holder's own read is still active.

// File: rtl/sem_pkg.sv
package sem_pkg;

  localparam int SEM_FLAGS = 8;
  localparam int SEM_IDX_W = $clog2(SEM_FLAGS);

  typedef enum logic [1:0] {
    HOLD_NONE = 2'd0,
    HOLD_L    = 2'd1,
    HOLD_R    = 2'd2
  } holder_e;

  typedef struct packed {
    logic                 wrL;
    logic                 wrR;
    logic                 claimL;
    logic                 claimR;
    logic [SEM_IDX_W-1:0] idxL;
    logic [SEM_IDX_W-1:0] idxR;
    logic                 capL;
    logic                 capR;
    logic                 showL;
    logic                 showR;
  } strobe_t;

  // Next owner of one token. The current holder keeps it while its own
  // request stays set. A free token goes to the left side first.
  function automatic holder_e nextHolder(holder_e cur, logic wantL, logic wantR);
    holder_e res;
    res = cur;
    unique case (cur)
      HOLD_L: if (!wantL) res = wantR ? HOLD_R : HOLD_NONE;
      HOLD_R: if (!wantR) res = wantL ? HOLD_L : HOLD_NONE;
      default: begin
        if (wantL)      res = HOLD_L;
        else if (wantR) res = HOLD_R;
        else            res = HOLD_NONE;
      end
    endcase
    return res;
  endfunction

endpackage

// File: rtl/sem_ctrl.sv
module sem_ctrl
  import sem_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              semSelL,
  input  logic              wrEnL,
  input  logic              rdEnL,
  input  logic [ADDR_W-1:0] addrL,
  input  logic [DATA_W-1:0] wrDataL,
  input  logic              semSelR,
  input  logic              wrEnR,
  input  logic              rdEnR,
  input  logic [ADDR_W-1:0] addrR,
  input  logic [DATA_W-1:0] wrDataR,
  output strobe_t           stb
);

  logic readL, readR;
  logic readQL, readQR;

  assign readL = semSelL & rdEnL;
  assign readR = semSelR & rdEnR;

  always_ff @(posedge clk) begin
    if (rst) begin
      readQL <= 1'b0;
      readQR <= 1'b0;
    end else begin
      readQL <= readL;
      readQR <= readR;
    end
  end

  always_comb begin
    stb        = '0;
    stb.wrL    = semSelL & wrEnL;
    stb.wrR    = semSelR & wrEnR;
    stb.claimL = ~wrDataL[0];
    stb.claimR = ~wrDataR[0];
    stb.idxL   = addrL[SEM_IDX_W-1:0];
    stb.idxR   = addrR[SEM_IDX_W-1:0];
    stb.capL   = readL & ~readQL;
    stb.capR   = readR & ~readQR;
    stb.showL  = readQL;
    stb.showR  = readQR;
  end

endmodule

// File: rtl/sem_flags.sv
module sem_flags
  import sem_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  strobe_t              stb,
  output logic [DATA_W-1:0]    rdDataL,
  output logic [DATA_W-1:0]    rdDataR,
  output logic [SEM_FLAGS-1:0] heldL,
  output logic [SEM_FLAGS-1:0] heldR
);

  logic [SEM_FLAGS-1:0] reqQL, reqQR;
  logic [DATA_W-1:0]    capRegL, capRegR;

  for (genvar f = 0; f < SEM_FLAGS; f++) begin : g_flag
    logic    reqNextL, reqNextR;
    holder_e holderQ;

    assign reqNextL = (stb.wrL && stb.idxL == SEM_IDX_W'(f)) ? stb.claimL : reqQL[f];
    assign reqNextR = (stb.wrR && stb.idxR == SEM_IDX_W'(f)) ? stb.claimR : reqQR[f];

    always_ff @(posedge clk) begin
      if (rst) begin
        reqQL[f] <= 1'b0;
        reqQR[f] <= 1'b0;
        holderQ  <= HOLD_NONE;
      end else begin
        reqQL[f] <= reqNextL;
        reqQR[f] <= reqNextR;
        holderQ  <= nextHolder(holderQ, reqNextL, reqNextR);
      end
    end

    assign heldL[f] = (holderQ == HOLD_L);
    assign heldR[f] = (holderQ == HOLD_R);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      capRegL <= '0;
      capRegR <= '0;
    end else begin
      if (stb.capL) capRegL <= {DATA_W{~heldL[stb.idxL]}};
      if (stb.capR) capRegR <= {DATA_W{~heldR[stb.idxR]}};
    end
  end

  assign rdDataL = stb.showL ? capRegL : '0;
  assign rdDataR = stb.showR ? capRegR : '0;

endmodule

// File: rtl/sem_token_unit.sv
module sem_token_unit
  import sem_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              semSelL,
  input  logic              wrEnL,
  input  logic              rdEnL,
  input  logic [ADDR_W-1:0] addrL,
  input  logic [DATA_W-1:0] wrDataL,
  output logic [DATA_W-1:0] rdDataL,
  input  logic              semSelR,
  input  logic              wrEnR,
  input  logic              rdEnR,
  input  logic [ADDR_W-1:0] addrR,
  input  logic [DATA_W-1:0] wrDataR,
  output logic [DATA_W-1:0] rdDataR
);

  strobe_t              stb;
  logic [SEM_FLAGS-1:0] heldL, heldR;

  sem_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst(rst),
    .semSelL(semSelL), .wrEnL(wrEnL), .rdEnL(rdEnL), .addrL(addrL), .wrDataL(wrDataL),
    .semSelR(semSelR), .wrEnR(wrEnR), .rdEnR(rdEnR), .addrR(addrR), .wrDataR(wrDataR),
    .stb(stb)
  );

  sem_flags #(.DATA_W(DATA_W)) u_flags (
    .clk(clk), .rst(rst), .stb(stb),
    .rdDataL(rdDataL), .rdDataR(rdDataR),
    .heldL(heldL), .heldR(heldR)
  );

endmodule

// File: rtl/sem_token_unit_chk.sv
module sem_token_unit_chk
  import sem_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int DATA_W = 16
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 semSelL,
  input logic                 wrEnL,
  input logic                 rdEnL,
  input logic [ADDR_W-1:0]    addrL,
  input logic [DATA_W-1:0]    wrDataL,
  input logic [DATA_W-1:0]    rdDataL,
  input logic                 semSelR,
  input logic                 wrEnR,
  input logic                 rdEnR,
  input logic [ADDR_W-1:0]    addrR,
  input logic [DATA_W-1:0]    wrDataR,
  input logic [DATA_W-1:0]    rdDataR,
  input logic [SEM_FLAGS-1:0] heldL,
  input logic [SEM_FLAGS-1:0] heldR
);

  logic actL, actR;
  assign actL = semSelL & rdEnL;
  assign actR = semSelR & rdEnR;

  p_one_holder_r6: assert property (@(posedge clk) disable iff (rst)
    (heldL & heldR) == '0);

  p_replicate_r4: assert property (@(posedge clk) disable iff (rst)
    (rdDataL == '0 || rdDataL == '1) && (rdDataR == '0 || rdDataR == '1));

  p_hold_read_l_r10: assert property (@(posedge clk) disable iff (rst)
    actL && $past(actL) |=> $stable(rdDataL));

  p_hold_read_r_r10: assert property (@(posedge clk) disable iff (rst)
    actR && $past(actR) |=> $stable(rdDataR));

  p_idle_zero_r10: assert property (@(posedge clk) disable iff (rst)
    !actL && !actR |=> rdDataL == '0 && rdDataR == '0);

  for (genvar f = 0; f < SEM_FLAGS; f++) begin : g_tok
    logic relL, relR, clmL, clmR;
    assign relL = semSelL && wrEnL && addrL[SEM_IDX_W-1:0] == SEM_IDX_W'(f) && wrDataL[0];
    assign relR = semSelR && wrEnR && addrR[SEM_IDX_W-1:0] == SEM_IDX_W'(f) && wrDataR[0];
    assign clmL = semSelL && wrEnL && addrL[SEM_IDX_W-1:0] == SEM_IDX_W'(f) && !wrDataL[0];
    assign clmR = semSelR && wrEnR && addrR[SEM_IDX_W-1:0] == SEM_IDX_W'(f) && !wrDataR[0];

    p_keep_l_r6: assert property (@(posedge clk) disable iff (rst)
      heldL[f] && !relL |=> heldL[f]);

    p_keep_r_r6: assert property (@(posedge clk) disable iff (rst)
      heldR[f] && !relR |=> heldR[f]);

    p_tie_left_r7: assert property (@(posedge clk) disable iff (rst)
      !heldL[f] && !heldR[f] && clmL && clmR |=> heldL[f]);

    p_grant_free_r5: assert property (@(posedge clk) disable iff (rst)
      !heldL[f] && !heldR[f] && clmR && !clmL |=> heldR[f]);
  end

endmodule

bind sem_token_unit sem_token_unit_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst),
  .semSelL(semSelL), .wrEnL(wrEnL), .rdEnL(rdEnL), .addrL(addrL), .wrDataL(wrDataL),
  .rdDataL(rdDataL),
  .semSelR(semSelR), .wrEnR(wrEnR), .rdEnR(rdEnR), .addrR(addrR), .wrDataR(wrDataR),
  .rdDataR(rdDataR),
  .heldL(heldL), .heldR(heldR)
);

// File: tb/sem_token_unit_bench.sv
module sem_token_unit_bench;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 14;
  localparam int DATA_W     = 16;
  localparam int WATCHDOG   = 5000;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              semSelL = 0, wrEnL = 0, rdEnL = 0;
  logic [ADDR_W-1:0] addrL = '0;
  logic [DATA_W-1:0] wrDataL = '0;
  logic [DATA_W-1:0] rdDataL;
  logic              semSelR = 0, wrEnR = 0, rdEnR = 0;
  logic [ADDR_W-1:0] addrR = '0;
  logic [DATA_W-1:0] wrDataR = '0;
  logic [DATA_W-1:0] rdDataR;

  int checks = 0;
  int fails  = 0;
  string curReq = "R1";

  // behavioural model: owner 0 free, 1 left, 2 right
  int          mReqL[8], mReqR[8], mOwn[8];
  bit          mActL, mActR;
  logic [15:0] mHoldL, mHoldR;

  always #(CLK_PERIOD/2) clk = ~clk;

  sem_token_unit #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sem_token_unit (
    .clk(clk), .rst(rst),
    .semSelL(semSelL), .wrEnL(wrEnL), .rdEnL(rdEnL), .addrL(addrL), .wrDataL(wrDataL),
    .rdDataL(rdDataL),
    .semSelR(semSelR), .wrEnR(wrEnR), .rdEnR(rdEnR), .addrR(addrR), .wrDataR(wrDataR),
    .rdDataR(rdDataR)
  );

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic modelStep();
    bit aL, aR;
    aL = semSelL && rdEnL;
    aR = semSelR && rdEnR;
    if (aL && !mActL) mHoldL = (mOwn[addrL % 8] == 1) ? 16'h0000 : 16'hFFFF;
    if (aR && !mActR) mHoldR = (mOwn[addrR % 8] == 2) ? 16'h0000 : 16'hFFFF;
    mActL = aL;
    mActR = aR;
    if (semSelL && wrEnL) mReqL[addrL % 8] = wrDataL[0] ? 0 : 1;
    if (semSelR && wrEnR) mReqR[addrR % 8] = wrDataR[0] ? 0 : 1;
    for (int f = 0; f < 8; f++) begin
      if (mOwn[f] == 1 && mReqL[f] == 0)      mOwn[f] = (mReqR[f] != 0) ? 2 : 0;
      else if (mOwn[f] == 2 && mReqR[f] == 0) mOwn[f] = (mReqL[f] != 0) ? 1 : 0;
      else if (mOwn[f] == 0)                  mOwn[f] = (mReqL[f] != 0) ? 1 : ((mReqR[f] != 0) ? 2 : 0);
    end
  endtask

  // apply current inputs for one clock, then compare both outputs
  task automatic tick();
    modelStep();
    @(posedge clk);
    @(negedge clk);
    check({curReq, " left"},  rdDataL, mActL ? mHoldL : 16'h0000);
    check({curReq, " right"}, rdDataR, mActR ? mHoldR : 16'h0000);
  endtask

  task automatic idle();
    semSelL = 0; wrEnL = 0; rdEnL = 0;
    semSelR = 0; wrEnR = 0; rdEnR = 0;
  endtask

  task automatic writeL(int a, logic [15:0] d);
    semSelL = 1; wrEnL = 1; rdEnL = 0; addrL = ADDR_W'(a); wrDataL = d;
  endtask

  task automatic writeR(int a, logic [15:0] d);
    semSelR = 1; wrEnR = 1; rdEnR = 0; addrR = ADDR_W'(a); wrDataR = d;
  endtask

  // read from both sides: strobe one cycle, value visible next cycle
  task automatic readBoth(int aLv, int aRv, logic [15:0] expL, logic [15:0] expR);
    idle();
    semSelL = 1; rdEnL = 1; addrL = ADDR_W'(aLv);
    semSelR = 1; rdEnR = 1; addrR = ADDR_W'(aRv);
    tick();
    idle();
    tick();
    // explicit expectation, independent of the model
    checks++;
    if (u_last_l !== expL || u_last_r !== expR) begin
      fails++;
      $display("FAIL %s read: actual %h/%h expected %h/%h", curReq, u_last_l, u_last_r, expL, expR);
    end
  endtask

  logic [15:0] u_last_l, u_last_r;
  always @(negedge clk) if (rdEnL || rdEnR || 1'b1) begin
    if (rdDataL !== 16'h0000 || rdDataR !== 16'h0000 || semSelL || semSelR) begin
      if (!(semSelL && rdEnL)) u_last_l = rdDataL;
      if (!(semSelR && rdEnR)) u_last_r = rdDataR;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails + 1, checks + 1);
    $finish;
  end

  initial begin
    for (int f = 0; f < 8; f++) begin mReqL[f] = 0; mReqR[f] = 0; mOwn[f] = 0; end
    mActL = 0; mActR = 0; mHoldL = '0; mHoldR = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: outputs zero, every token free from both sides
    curReq = "R1";
    check("R1 idle left", rdDataL, 16'h0000);
    check("R1 idle right", rdDataR, 16'h0000);
    for (int f = 0; f < 8; f++) readBoth(f, f, 16'hFFFF, 16'hFFFF);

    // R3 R5 R4: left claims token 2 with upper data bits set
    curReq = "R3";
    writeL(2, 16'hFFFE); tick(); idle();
    curReq = "R4";
    readBoth(2, 2, 16'h0000, 16'hFFFF);

    // R2: right claims token 5 through an aliased address
    curReq = "R2";
    writeR(14'h2A5, 16'h0000); tick(); idle();
    readBoth(14'h1005, 14'h3FFD, 16'hFFFF, 16'h0000);

    // R6: right requests token 2 held by left, left keeps it
    curReq = "R6";
    writeR(2, 16'h1230); tick(); idle(); tick();
    readBoth(2, 2, 16'h0000, 16'hFFFF);

    // R8: left releases token 2, pending right request takes over
    curReq = "R8";
    writeL(2, 16'h0001); tick(); idle();
    readBoth(2, 2, 16'hFFFF, 16'h0000);

    // R9: left queues then withdraws, right releases -> free
    curReq = "R9";
    writeL(2, 16'h0000); tick();
    writeL(2, 16'h0001); tick(); idle();
    writeR(2, 16'hFFFF); tick(); idle();
    readBoth(2, 2, 16'hFFFF, 16'hFFFF);

    // R7: same-edge tie on free token 6
    curReq = "R7";
    writeL(6, 16'h0000); writeR(6, 16'h0000); tick(); idle();
    readBoth(6, 6, 16'h0000, 16'hFFFF);

    // R10: left read of token 6 held; left releases while still reading
    curReq = "R10";
    semSelL = 1; rdEnL = 1; addrL = 6; tick();
    wrEnL = 1; wrDataL = 16'h0001; tick();
    wrEnL = 0; addrL = 3; tick(); tick();
    check("R10 held left", rdDataL, 16'h0000);
    idle(); tick();
    check("R10 idle left", rdDataL, 16'h0000);
    curReq = "R8";
    readBoth(6, 6, 16'hFFFF, 16'h0000);

    // R11: other tokens untouched; token 5 still right, 0 free
    curReq = "R11";
    readBoth(5, 5, 16'hFFFF, 16'h0000);
    readBoth(0, 7, 16'hFFFF, 16'hFFFF);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule